// File: doc/BRIEF.md
# Bit-Clock Ratio Detector and PDM Clock Generator

This block sits in front of a PDM decimator whose serial audio port is driven by an external bit clock and frame clock. It finds out, with no configuration, how many bit-clock cycles make up one frame, and sorts that count into one of six supported ratios: 64, 128, 192, 256, 384 or 512. Once a ratio has been confirmed, it divides the bit clock down so that the PDM microphones see a clock of exactly 64 periods per frame. For frame rates from 4 kHz to 96 kHz, that gives a PDM clock between 256 kHz and 6.144 MHz.

The bit clock and frame clock are sampled by a free-running monitor clock. The monitor clock must run at least four times faster than the fastest bit clock. Both bit-clock edges advance the divider. Because of that, the divide-by-three case still has an even duty cycle. The divider is realigned at every frame start, which is the falling edge of the frame clock.

If no bit-clock edge is seen for a programmable number of monitor cycles, the block does three things in that same cycle: it stops the PDM clock, drops the lock and raises a power-down flag. The first bit-clock edge that comes back clears the flag. The lock is then rebuilt from fresh measurements.

Top module: `bclk_ratio_pdmclk`

## Requirements
- R1: While reset is high and on the first cycle after it, `locked` = 0, `pdm_clk` = 0, `ratio_code` = 0 and `powerdown` = 1.
- R2: A locked count is reported on `ratio_code` as follows: 0 for 64, 1 for 128, 2 for 192, 3 for 256, 4 for 384 and 5 for 512. The count is the number of rising edges of `bclk_in` between two falling edges of `lrclk_in`.
- R3: `locked` rises at a frame start only if the frame that just ended and the frame before it both measured the same supported count. The first frame start after reset, or after a bit-clock loss, only begins a measurement.
- R4: A count outside the supported set clears `locked` at the frame start that ends that frame. `pdm_clk` is low whenever `locked` is low.
- R5: Suppose the block is locked and the measured count changes. It unlocks at the first frame start that reports the new count, and it locks to the new count at the following frame start.
- R6: While locked and away from a frame start, `pdm_clk` inverts after every m sampled edges of `bclk_in`, counting both rising and falling edges. Here m is 1, 2, 3, 4, 6 or 8 for codes 0 to 5.
- R7: At each frame start that leaves the block locked, `pdm_clk` is driven high and the edge count restarts. A locked frame therefore holds exactly 64 rising edges of `pdm_clk`.
- R8: Suppose TIMEOUT_CYC monitor cycles pass without any edge of `bclk_in`. In the cycle that ends the count, `powerdown` rises and both `locked` and `pdm_clk` fall. This holds even if a frame start arrives in that same cycle.
- R9: `powerdown` falls in the cycle after the first sampled `bclk_in` edge.
- R10: `ratio_code` changes only at a frame start where lock is confirmed. It holds its value while the block is unlocked or powered down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, sampled by `clk` |
| lrclk_in | input | 1 | Frame clock; a falling edge marks the start of a frame |
| pdm_clk | output | 1 | Derived PDM clock, 64 periods per frame |
| ratio_code | output | 3 | Locked ratio code, see R2 |
| locked | output | 1 | Ratio confirmed and PDM clock running |
| powerdown | output | 1 | Bit clock absent |

## Verification
Two events can land in the same monitor cycle, and each must win cleanly. The first pair is the frame-start realignment and a divider step. In normal traffic the frame clock changes together with the falling bit-clock edge, so every frame start tests that the realignment takes priority over the step. The second pair is the frame-start realignment and the loss timeout. The bench stops the bit clock and then times the falling edge of the frame clock to arrive in exactly the cycle in which the idle count expires. In that cycle the loss must win: no high phase is re-armed, and the lock is not refreshed. A behavioural reference model, written from the requirements, predicts all four outputs. The bench compares them against the model on every monitor cycle.

// File: rtl/pdmck_pkg.sv
package pdmck_pkg;
  localparam int PDM_PER_FRAME = 64;
  localparam int NUM_RATIOS    = 6;
  localparam int CODE_W        = 3;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  ok;
    code_t code;
  } cls_t;

  // bit-clock cycles per PDM period for each ratio code
  function automatic logic [3:0] code_mult(input code_t c);
    logic [3:0] m;
    case (c)
      3'd0:    m = 4'd1;
      3'd1:    m = 4'd2;
      3'd2:    m = 4'd3;
      3'd3:    m = 4'd4;
      3'd4:    m = 4'd6;
      3'd5:    m = 4'd8;
      default: m = 4'd0;
    endcase
    return m;
  endfunction

  function automatic cls_t classify(input int unsigned n);
    cls_t r;
    r = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (n == PDM_PER_FRAME * int'(code_mult(code_t'(i)))) begin
        r.ok   = 1'b1;
        r.code = code_t'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pdmck_edges.sv
module pdmck_edges (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lrclk_in,
  output logic b_edge,
  output logic b_rise,
  output logic f_edge
);
  logic b_q, l_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= 1'b0;
      l_q <= 1'b0;
    end else begin
      b_q <= bclk_in;
      l_q <= lrclk_in;
    end
  end

  assign b_edge = bclk_in ^ b_q;
  assign b_rise = bclk_in & ~b_q;
  assign f_edge = ~lrclk_in & l_q;
endmodule

// File: rtl/pdmck_watch.sv
module pdmck_watch #(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic b_edge,
  output logic lost,
  output logic powerdown
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] T_SAT  = TW'(TIMEOUT_CYC);

  logic [TW-1:0] idle;

  assign lost = ~b_edge & (idle == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle      <= '0;
      powerdown <= 1'b1;
    end else if (b_edge) begin
      idle      <= '0;
      powerdown <= 1'b0;
    end else begin
      if (idle != T_SAT) idle <= idle + 1'b1;
      if (lost) powerdown <= 1'b1;
    end
  end

  p_pd_clear_r9: assert property (@(posedge clk) disable iff (rst)
    b_edge |=> !powerdown);
endmodule

// File: rtl/pdmck_ratio.sv
module pdmck_ratio
  import pdmck_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  b_rise,
  input  logic  f_edge,
  input  logic  lost,
  output logic  locked,
  output logic  lock_d,
  output code_t ratio_code
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             seen, prev_ok;
  code_t            prev_code;
  cls_t             cls;
  logic             new_lock;

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (f_edge)                   cnt <= CNT_W'(b_rise);
    else if (b_rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_comb begin
    cls      = classify(32'(cnt));
    new_lock = seen & cls.ok & prev_ok & (prev_code == cls.code);
    if (lost)        lock_d = 1'b0;
    else if (f_edge) lock_d = new_lock;
    else             lock_d = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked     <= 1'b0;
      ratio_code <= '0;
      seen       <= 1'b0;
      prev_ok    <= 1'b0;
      prev_code  <= '0;
    end else if (lost) begin
      locked  <= 1'b0;
      seen    <= 1'b0;
      prev_ok <= 1'b0;
    end else if (f_edge) begin
      seen      <= 1'b1;
      locked    <= new_lock;
      prev_ok   <= seen & cls.ok;
      prev_code <= cls.code;
      if (new_lock) ratio_code <= cls.code;
    end
  end

  p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !f_edge |=> $stable(ratio_code));
endmodule

// File: rtl/pdmck_div.sv
module pdmck_div
  import pdmck_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  b_edge,
  input  logic  f_edge,
  input  logic  lost,
  input  logic  locked,
  input  logic  lock_d,
  input  code_t ratio_code,
  output logic  pdm_clk
);
  logic [3:0] half;
  logic [3:0] dcnt;

  assign half = code_mult(ratio_code);

  always_ff @(posedge clk) begin
    if (rst || lost) begin
      pdm_clk <= 1'b0;
      dcnt    <= '0;
    end else if (f_edge) begin
      pdm_clk <= lock_d;
      dcnt    <= '0;
    end else if (!locked) begin
      pdm_clk <= 1'b0;
      dcnt    <= '0;
    end else if (b_edge) begin
      if (dcnt == half - 4'd1) begin
        pdm_clk <= ~pdm_clk;
        dcnt    <= '0;
      end else begin
        dcnt <= dcnt + 4'd1;
      end
    end
  end

  p_pdm_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && !b_edge && !f_edge && !lost) |=> $stable(pdm_clk));
endmodule

// File: rtl/bclk_ratio_pdmclk.sv
module bclk_ratio_pdmclk
  import pdmck_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              lrclk_in,
  output logic              pdm_clk,
  output logic [CODE_W-1:0] ratio_code,
  output logic              locked,
  output logic              powerdown
);
  logic b_edge, b_rise, f_edge, lost, lock_d;

  pdmck_edges u_edges (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .b_edge(b_edge), .b_rise(b_rise), .f_edge(f_edge)
  );

  pdmck_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst(rst), .b_edge(b_edge), .lost(lost), .powerdown(powerdown)
  );

  pdmck_ratio #(.CNT_W(CNT_W)) u_ratio (
    .clk(clk), .rst(rst), .b_rise(b_rise), .f_edge(f_edge), .lost(lost),
    .locked(locked), .lock_d(lock_d), .ratio_code(ratio_code)
  );

  pdmck_div u_div (
    .clk(clk), .rst(rst), .b_edge(b_edge), .f_edge(f_edge), .lost(lost),
    .locked(locked), .lock_d(lock_d), .ratio_code(ratio_code), .pdm_clk(pdm_clk)
  );

  p_stop_on_loss_r8: assert property (@(posedge clk) disable iff (rst)
    lost |=> (powerdown && !locked && !pdm_clk));

  p_pd_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
    powerdown |-> !locked);

  p_quiet_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !pdm_clk);
endmodule

// File: tb/sim_bclk_ratio_pdmclk.sv
module sim_bclk_ratio_pdmclk;
  localparam int TO = 16;
  localparam int H  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_in = 1'b0;
  logic lrclk_in = 1'b1;
  logic pdm_clk, locked, powerdown;
  logic [2:0] ratio_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bclk_ratio_pdmclk #(.CNT_W(10), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .pdm_clk(pdm_clk), .ratio_code(ratio_code), .locked(locked), .powerdown(powerdown)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int ratio_of(input int n);
    case (n)
      64: return 0;  128: return 1; 192: return 2;
      256: return 3; 384: return 4; 512: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int step_of(input int c);
    int tbl[6] = '{1, 2, 3, 4, 6, 8};
    return tbl[c];
  endfunction

  int pb, pl, rises, idle, seen, prev, ek;
  int e_pdm, e_lock, e_code, e_pd;

  always @(posedge clk) begin
    if (rst) begin
      pb = 0; pl = 0; rises = 0; idle = 0; seen = 0; prev = -1; ek = 0;
      e_pdm = 0; e_lock = 0; e_code = 0; e_pd = 1;
    end else begin
      int be, br, fe, gone, m;
      be = (int'(bclk_in) != pb);
      br = (bclk_in && pb == 0);
      fe = (!lrclk_in && pl == 1);
      pb = int'(bclk_in);
      pl = int'(lrclk_in);
      gone = 0;
      if (be) begin idle = 0; e_pd = 0; end
      else begin
        idle++;
        if (idle == TO) begin gone = 1; e_pd = 1; end
      end
      if (gone) begin
        e_lock = 0; seen = 0; prev = -1;
      end else if (fe) begin
        m = ratio_of(rises);
        if (seen == 0) begin
          seen = 1; prev = m;
        end else begin
          if (m >= 0 && m == prev) begin e_lock = 1; e_code = m; end
          else e_lock = 0;
          prev = m;
        end
      end
      if (fe) rises = br; else rises += br;
      if (gone) begin e_pdm = 0; ek = 0; end
      else if (fe) begin ek = 0; e_pdm = e_lock; end
      else if (!e_lock) e_pdm = 0;
      else begin
        if (be) ek++;
        e_pdm = ((ek / step_of(e_code)) % 2 == 0);
      end
    end
  end

  // compare every cycle, away from the active edge
  int pdm_rises = 0;
  logic last_pdm = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(pdm_clk) == e_pdm, "R6 pdm_clk", int'(pdm_clk), e_pdm);
      check(int'(locked) == e_lock, "R3 locked", int'(locked), e_lock);
      check(int'(ratio_code) == e_code, "R2/R10 ratio_code", int'(ratio_code), e_code);
      check(int'(powerdown) == e_pd, "R8/R9 powerdown", int'(powerdown), e_pd);
      if (pdm_clk && !last_pdm) pdm_rises++;
      last_pdm = pdm_clk;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_frames(input int r, input int n);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < r; b++) begin
        @(negedge clk);
        bclk_in = 1'b0;
        lrclk_in = (b >= r / 2);
        repeat (H - 1) @(negedge clk);
        @(negedge clk);
        bclk_in = 1'b1;
        repeat (H - 1) @(negedge clk);
      end
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int snap;
    int rl[6] = '{64, 128, 192, 256, 384, 512};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(locked == 1'b0, "R1 locked", int'(locked), 0);
    check(pdm_clk == 1'b0, "R1 pdm_clk", int'(pdm_clk), 0);
    check(ratio_code == 3'd0, "R1 ratio_code", int'(ratio_code), 0);
    check(powerdown == 1'b1, "R1 powerdown", int'(powerdown), 1);

    // R2 / R3: every supported ratio locks after two matching frames
    for (int i = 0; i < 6; i++) begin
      run_frames(rl[i], 3);
      check(locked == 1'b1, "R3 lock", int'(locked), 1);
      check(int'(ratio_code) == i, "R2 code", int'(ratio_code), i);
    end

    // R7: 64 PDM periods in one locked frame at divide-by-3
    run_frames(192, 3);
    snap = pdm_rises;
    run_frames(192, 1);
    check(pdm_rises - snap == 64, "R7 periods per frame", pdm_rises - snap, 64);

    // R4: unsupported count
    run_frames(100, 3);
    check(locked == 1'b0, "R4 unlocked", int'(locked), 0);
    check(pdm_clk == 1'b0, "R4 pdm low", int'(pdm_clk), 0);

    // R5: ratio change unlocks then relocks
    run_frames(128, 3);
    check(locked == 1'b1, "R5 lock 128", int'(locked), 1);
    run_frames(256, 2);
    check(locked == 1'b0, "R5 unlock on change", int'(locked), 0);
    run_frames(256, 1);
    check(locked == 1'b1 && ratio_code == 3'd3, "R5 relock 256", int'(ratio_code), 3);

    // R8 / R10: bit clock stops
    repeat (TO + 2) @(negedge clk);
    check(powerdown == 1'b1, "R8 powerdown", int'(powerdown), 1);
    check(locked == 1'b0, "R8 unlock", int'(locked), 0);
    check(pdm_clk == 1'b0, "R8 pdm stopped", int'(pdm_clk), 0);
    check(ratio_code == 3'd3, "R10 code held", int'(ratio_code), 3);

    // R9: first edge clears power-down
    @(negedge clk);
    bclk_in = 1'b0;
    @(negedge clk);
    check(powerdown == 1'b0, "R9 powerdown cleared", int'(powerdown), 0);
    run_frames(64, 3);
    check(locked == 1'b1 && ratio_code == 3'd0, "R3 relock after loss", int'(ratio_code), 0);

    // R8: loss and frame start in the same cycle
    run_frames(256, 3);
    check(locked == 1'b1, "R3 lock before collision", int'(locked), 1);
    repeat (TO - (H - 1)) @(negedge clk);
    lrclk_in = 1'b0;
    @(negedge clk);
    check(powerdown == 1'b1, "R8 collision powerdown", int'(powerdown), 1);
    check(locked == 1'b0, "R8 collision unlock", int'(locked), 0);
    check(pdm_clk == 1'b0, "R8 collision pdm", int'(pdm_clk), 0);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end
endmodule